// File: doc/BRIEF.md
# Vertical Sync Separator with Noise Shaping

This block finds the vertical sync inside a composite sync stream that is sampled on the master clock. Positive-polarity sync is first brought into the clock domain through a two-flop synchronizer. It is then noise-shaped: a recovery stretcher holds the shaped level active across short low gaps. Serrations and equalizing notches narrower than the recovery time therefore merge into one continuous pulse. Gaps that are wider pass through.

A rising edge of the shaped sync opens a measurement window of fixed length. Inside the window, every cycle of active shaped sync adds to an accumulator. A cycle adds two while it is in the leading decision sub-window and one after that sub-window. When the sum reaches the threshold, the block emits a V-reset pulse one clock wide. The window then locks out further decisions until it ends. A window that ends without a decision clears the accumulator.

A line-start reference drives a horizontal position counter. At the same edge as the V-reset, the block latches a field-identity bit from that position. The V-reset and the field bit are used to restart the vertical timing of a display timing generator. All durations are parameters in master-clock cycles. The defaults assume a 12 MHz clock: 15 µs recovery, a 190 µs window, a 125 µs decision sub-window and a 63.5 µs line.

Top module: `vsync_sep`

## Requirements
- R1: The sync input passes through exactly two flip-flops before it is weighed. For sync held active from an idle state, the V-reset goes high on the (THRESH_CYC/2 + 2)th rising clock edge after the input becomes active.
- R2: A low gap in the synchronized sync of at most REC_CYC cycles is filled. The shaped sync stays active across the gap, so a train of short sync pulses separated by such gaps accumulates as one continuous pulse.
- R3: A low gap longer than REC_CYC cycles ends the shaped pulse. The shaped pulse lasts the input width plus REC_CYC cycles, so sparse narrow pulses cause no V-reset.
- R4: A shaped-active cycle whose window position is below DEC_CYC adds 2 to the accumulator. A decision is taken when the sum is greater than or equal to THRESH_CYC.
- R5: A shaped-active cycle at window position DEC_CYC or later adds 1 to the accumulator.
- R6: A window that runs WIN_CYC cycles without a decision clears the accumulator. Sync seen in an earlier window never counts toward a later one.
- R7: A V-reset is high for exactly one cycle. A window yields at most one V-reset, and a new window opens only on a rising edge of the shaped sync.
- R8: At each V-reset, field_o is loaded with 1 if the horizontal position since the last line_start_i is below LINE_CYC/2, and with 0 otherwise. field_o changes at no other time.
- R9: While rst_ni is low, vreset_o and field_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csync_i | input | 1 | Composite sync, active high, asynchronous to clk_i |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| vreset_o | output | 1 | One-cycle vertical reset pulse |
| field_o | output | 1 | Field identity: 1 when the V-reset fell in the first half of the line |

## Verification
The case that is hardest to reach from the ports is a decision that turns on the position of a pulse inside the window. The same pulse has to tip the sum over the threshold when it lies in the decision sub-window and fall short when it lies after it. The stimulus opens a window with a one-cycle pulse of known shaped length. It then places a second pulse of fixed width a set number of cycles later, once inside and once beyond the sub-window. Window expiry is reached the same way, with a third pulse placed after the window end so that only a stale accumulator would reach the threshold.

// File: rtl/vsep_pkg.sv
package vsep_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_ACT  = 2'd1,
    WIN_HOLD = 2'd2
  } win_state_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vsep_sync.sv
module vsep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vsep_shaper.sv
module vsep_shaper #(
  parameter int unsigned REC_CYC = 180
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic shaped_o
);
  import vsep_pkg::*;

  localparam int unsigned HW = cnt_w(REC_CYC + 1);
  localparam logic [HW-1:0] REC_LD = HW'(REC_CYC);

  logic [HW-1:0] hold_q;

  // reload while sync is active, drain through the gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (sync_i)          hold_q <= REC_LD;
    else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  assign shaped_o = sync_i | (hold_q != '0);
endmodule

// File: rtl/vsep_window.sv
module vsep_window #(
  parameter int unsigned WIN_CYC    = 2280,
  parameter int unsigned DEC_CYC    = 1500,
  parameter int unsigned THRESH_CYC = 2400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shaped_i,
  output logic decide_o,
  output logic vreset_o
);
  import vsep_pkg::*;

  localparam int unsigned PW = cnt_w(WIN_CYC + 1);
  localparam int unsigned AW = cnt_w(2 * WIN_CYC + 2) + 1;
  localparam logic [PW-1:0] POS_LAST = PW'(WIN_CYC - 1);
  localparam logic [PW-1:0] POS_DEC  = PW'(DEC_CYC);
  localparam logic [AW-1:0] THR      = AW'(THRESH_CYC);

  win_state_e    st_q;
  logic [PW-1:0] pos_q;
  logic [AW-1:0] acc_q;
  logic          shaped_prev_q;
  logic          vreset_q;

  logic          start;
  logic          counting;
  logic          expire;
  logic [1:0]    wgt;
  logic [AW-1:0] acc_sum;

  always_comb begin
    start    = (st_q == WIN_IDLE) && shaped_i && !shaped_prev_q;
    counting = start || (st_q == WIN_ACT);
    expire   = (pos_q == POS_LAST);
    if (!shaped_i)             wgt = 2'd0;
    else if (pos_q < POS_DEC)  wgt = 2'd2;
    else                       wgt = 2'd1;
    acc_sum  = acc_q + AW'(wgt);
    decide_o = counting && (acc_sum >= THR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= WIN_IDLE;
      pos_q         <= '0;
      acc_q         <= '0;
      shaped_prev_q <= 1'b0;
      vreset_q      <= 1'b0;
    end else begin
      shaped_prev_q <= shaped_i;
      vreset_q      <= decide_o;
      unique case (st_q)
        WIN_IDLE: begin
          if (start) begin
            pos_q <= PW'(1);
            if (decide_o) begin
              st_q  <= WIN_HOLD;
              acc_q <= '0;
            end else begin
              st_q  <= WIN_ACT;
              acc_q <= acc_sum;
            end
          end
        end
        WIN_ACT: begin
          if (decide_o) begin
            st_q  <= expire ? WIN_IDLE : WIN_HOLD;
            pos_q <= expire ? '0 : pos_q + 1'b1;
            acc_q <= '0;
          end else if (expire) begin
            st_q  <= WIN_IDLE;
            pos_q <= '0;
            acc_q <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
            acc_q <= acc_sum;
          end
        end
        WIN_HOLD: begin
          if (expire) begin
            st_q  <= WIN_IDLE;
            pos_q <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        default: begin
          st_q  <= WIN_IDLE;
          pos_q <= '0;
          acc_q <= '0;
        end
      endcase
    end
  end

  assign vreset_o = vreset_q;
endmodule

// File: rtl/vsep_field.sv
module vsep_field #(
  parameter int unsigned LINE_CYC = 762
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_start_i,
  input  logic decide_i,
  output logic field_o
);
  import vsep_pkg::*;

  localparam int unsigned HW = cnt_w(LINE_CYC + 1);
  localparam logic [HW-1:0] H_MAX  = HW'(LINE_CYC);
  localparam logic [HW-1:0] H_HALF = HW'(LINE_CYC / 2);

  logic [HW-1:0] hpos_q;
  logic          field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hpos_q <= '0;
    else if (line_start_i)       hpos_q <= '0;
    else if (hpos_q != H_MAX)    hpos_q <= hpos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       field_q <= 1'b0;
    else if (decide_i) field_q <= (hpos_q < H_HALF);
  end

  assign field_o = field_q;
endmodule

// File: rtl/vsync_sep.sv
module vsync_sep #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REC_CYC     = 180,
  parameter int unsigned WIN_CYC     = 2280,
  parameter int unsigned DEC_CYC     = 1500,
  parameter int unsigned THRESH_CYC  = 2400,
  parameter int unsigned LINE_CYC    = 762
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_i,
  input  logic line_start_i,
  output logic vreset_o,
  output logic field_o
);
  logic sync_w;
  logic shaped_w;
  logic decide_w;

  vsep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (csync_i),
    .q_o   (sync_w)
  );

  vsep_shaper #(.REC_CYC(REC_CYC)) u_shaper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_w),
    .shaped_o(shaped_w)
  );

  vsep_window #(
    .WIN_CYC   (WIN_CYC),
    .DEC_CYC   (DEC_CYC),
    .THRESH_CYC(THRESH_CYC)
  ) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shaped_i(shaped_w),
    .decide_o(decide_w),
    .vreset_o(vreset_o)
  );

  vsep_field #(.LINE_CYC(LINE_CYC)) u_field (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start_i),
    .decide_i    (decide_w),
    .field_o     (field_o)
  );
endmodule

// File: rtl/vsync_sep_chk.sv
module vsync_sep_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vreset_o,
  input logic field_o,
  input logic sync_w,
  input logic shaped_w
);
  a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vreset_o |=> !vreset_o);

  a_r8_field_only_on_vreset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_o) |-> vreset_o);

  // R2, R3: shaped sync may only end after the raw sync has been low a cycle
  a_r2_no_early_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shaped_w) |-> (!sync_w && $past(!sync_w)));

  a_r4_vreset_needs_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vreset_o |-> $past(shaped_w));

  a_r9_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (!vreset_o && !field_o));
endmodule

bind vsync_sep vsync_sep_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vreset_o(vreset_o),
  .field_o (field_o),
  .sync_w  (sync_w),
  .shaped_w(shaped_w)
);

// File: tb/vsync_sep_bench.sv
module vsync_sep_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REC  = 4;
  localparam int WIN  = 60;
  localparam int DEC  = 20;
  localparam int THR  = 30;
  localparam int LINE = 64;

  typedef struct {
    int    exp_pulses;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync = 1'b0;
  logic line_start = 1'b0;
  logic vreset;
  logic field;

  int total = 0;
  int bad = 0;
  int pulse_cnt = 0;
  int ls_cnt = 0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_sep #(
    .SYNC_STAGES(2), .REC_CYC(REC), .WIN_CYC(WIN),
    .DEC_CYC(DEC), .THRESH_CYC(THR), .LINE_CYC(LINE)
  ) u_vsync_sep (
    .clk_i(clk), .rst_ni(rst_n), .csync_i(csync),
    .line_start_i(line_start), .vreset_o(vreset), .field_o(field)
  );

  // line reference and pulse monitor
  always @(negedge clk) begin
    ls_cnt     <= (ls_cnt == LINE - 1) ? 0 : ls_cnt + 1;
    line_start <= (ls_cnt == LINE - 1);
    if (rst_n && vreset === 1'b1) pulse_cnt <= pulse_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic drive(input logic lvl, input int cyc);
    csync = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic push_exp(input int n, input string tag);
    exp_t e;
    e.exp_pulses = n;
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    pulse_cnt = 0;
  endtask

  task automatic close_case();
    exp_t e;
    drive(1'b0, 120);
    e = sb_q.pop_front();
    check(e.tag, pulse_cnt, e.exp_pulses);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 vreset in reset", int'(vreset), 0);
    check("R9 field in reset", int'(field), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: latency of a held sync, THR/2 + 2 edges
    begin
      int lat = 0;
      pulse_cnt = 0;
      csync = 1'b1;
      while (vreset !== 1'b1 && lat < 100) begin
        @(negedge clk);
        lat++;
      end
      check("R1 latency", lat, THR/2 + 2);
      drive(1'b1, 60);
      drive(1'b0, 120);
    end

    // R10-like normal line sync train: no vertical reset
    push_exp(0, "R3 hsync train");
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, 3);
      drive(1'b0, 29);
    end
    close_case();

    // R2: serrations with gaps within recovery merge
    push_exp(1, "R2 narrow gaps filled");
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 1);
      drive(1'b0, 3);
    end
    close_case();

    // R3: gaps wider than recovery are not filled
    push_exp(0, "R3 wide gaps");
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, 1);
      drive(1'b0, 20);
    end
    close_case();

    // R4: pulse inside decision sub-window counts double (10 + 22 >= 30)
    push_exp(1, "R4 double weight");
    drive(1'b1, 1);
    drive(1'b0, 7);
    drive(1'b1, 7);
    close_case();

    // R5: same pulse after sub-window counts single (10 + 11 < 30)
    push_exp(0, "R5 single weight");
    drive(1'b1, 1);
    drive(1'b0, 29);
    drive(1'b1, 7);
    close_case();

    // R6: sum split over two windows must not decide (20 + 20)
    push_exp(0, "R6 expiry clears");
    drive(1'b1, 1);
    drive(1'b0, 29);
    drive(1'b1, 6);
    drive(1'b0, 29);
    drive(1'b1, 6);
    close_case();

    // R7: long sync gives one pulse
    push_exp(1, "R7 one per window");
    drive(1'b1, 150);
    close_case();

    push_exp(2, "R7 two separate windows");
    drive(1'b1, 40);
    drive(1'b0, 100);
    drive(1'b1, 40);
    close_case();

    // R8: field from position inside the line
    while (ls_cnt != 2) @(negedge clk);
    drive(1'b1, 40);
    check("R8 first half field", int'(field), 1);
    drive(1'b0, 120);
    while (ls_cnt != 40) @(negedge clk);
    drive(1'b1, 40);
    check("R8 second half field", int'(field), 0);
    drive(1'b0, 200);
    check("R8 field holds", int'(field), 0);

    // R9: reset mid-operation
    drive(1'b1, 10);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 vreset after reset", int'(vreset), 0);
    check("R9 field after reset", int'(field), 0);
    csync = 1'b0;
    finish_run();
  end
endmodule